// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block takes exception requests from a processor pipeline and performs the whole entry step in a single clock edge. It updates the architectural exception state and produces a new fetch address sequence. That state covers the exception-level flag, the cause code, the branch-delay flag, the coprocessor field, the exception return address, the faulting virtual address, the translation-fault fields and the shadow register set selectors. The fetch sequence is a handler PC, the PC after it and the PC after that.

A request is one cycle of `exc_valid` with a kind, the PC and next PC of the faulting instruction, and the side information that kind needs. The handler address is worked out from the exception base, the boot-vector flag, the interrupt-vector flag and the exception-level flag as it stood before this entry. Every update in one entry sees the register values from before that entry. Reset puts the fetch sequence at the boot address and marks coprocessor 1 usable. Leaving the handler is outside this block, as are the translation lookup and interrupt arbitration.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `pc_o`=0xBFC00000, `npc_o`=0xBFC00004, `nnpc_o`=0xBFC00008 and `cu1_o`=1. `exl_o`, `bd_o`, `exc_code_o`, `ce_o`, `epc_o`, `badva_o`, the translation fields, `css_o` and `pss_o` are all 0.
- R2: Every accepted request sets `exl_o` to 1 on that clock edge, whether or not it was already 1.
- R3: When `exc_pc`+4 differs from `exc_npc`, the entry writes `epc_o`=`exc_pc`-4 and `bd_o`=1. Otherwise it writes `epc_o`=`exc_pc` and `bd_o`=0.
- R4: `exc_kind` is decoded into `exc_code_o` as follows: 0 interrupt→0, 1 translation modified→1, 2 load/fetch refill→2, 3 load/fetch invalid→2, 4 store refill→3, 5 store invalid→3, 6 load address error→4, 7 store address error→5, 8 system call→8, 9 breakpoint→9, 10 reserved instruction→0xA, 11 coprocessor unusable→0xB, 12 overflow→0xC, 13 trap→0xD. Kinds 14 and 15 are handled as reserved instruction.
- R5: `ce_o` takes `exc_cop` for kind 11 and is cleared for every other kind.
- R6: When `exl_o` and `cfg_bev` are both 0 before the entry, `pss_o` takes the old `css_o` and `css_o` takes `cfg_ess`. Otherwise both keep their values.
- R7: Refill kinds (2, 4) vector to `cfg_ebase` when the old `exl_o` is 0, and to `cfg_ebase`+0x180 when it is 1.
- R8: An interrupt (kind 0) vectors to `cfg_ebase`+0x200 when `cfg_iv`=1, and to `cfg_ebase`+0x180 when `cfg_iv`=0.
- R9: Overflow (kind 12) with `cfg_bev`=1 vectors to 0xBFC00200. Every other non-refill, non-interrupt case vectors to `cfg_ebase`+0x180.
- R10: Translation kinds (1–5) load `badva_o`, `hi_asid_o`, `hi_vpn2_o`, `hi_vpn2x_o` and `ctx_vpn2_o` from the request. Address errors (6, 7) load only `badva_o`. All other kinds leave these five unchanged.
- R11: After an entry, `pc_o` is the handler, `npc_o` is the handler+4 and `nnpc_o` is the handler+8.
- R12: A cycle without `exc_valid` changes no output, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | One-cycle request strobe |
| exc_kind | input | 4 | Exception kind (encoding in R4) |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_npc | input | 32 | Next PC at the time of the fault |
| exc_badva | input | 32 | Faulting virtual address |
| exc_asid | input | 8 | Address space id for the translation fault |
| exc_vpn2 | input | 19 | Virtual page pair number |
| exc_vpn2x | input | 2 | Extended page pair bits |
| exc_ctx_vpn2 | input | 19 | Page pair number for the context register |
| exc_cop | input | 2 | Coprocessor number for kind 11 |
| cfg_ebase | input | 32 | Exception base address |
| cfg_bev | input | 1 | Boot-vector flag |
| cfg_iv | input | 1 | Dedicated interrupt vector flag |
| cfg_ess | input | 4 | Shadow set used on exceptions |
| pc_o | output | 32 | Fetch PC |
| npc_o | output | 32 | Fetch PC + 4 |
| nnpc_o | output | 32 | Fetch PC + 8 |
| exl_o | output | 1 | Exception-level flag |
| cu1_o | output | 1 | Coprocessor 1 usable |
| exc_code_o | output | 5 | Cause code |
| bd_o | output | 1 | Branch-delay flag |
| ce_o | output | 2 | Coprocessor field of the cause |
| epc_o | output | 32 | Exception return address |
| badva_o | output | 32 | Recorded faulting address |
| hi_asid_o | output | 8 | Recorded address space id |
| hi_vpn2_o | output | 19 | Recorded page pair number |
| hi_vpn2x_o | output | 2 | Recorded extended page bits |
| ctx_vpn2_o | output | 19 | Context page pair number |
| css_o | output | 4 | Current shadow set |
| pss_o | output | 4 | Previous shadow set |

## Verification
Refill requests are issued once right after reset and once after another exception. This shows whether the vector uses the old exception-level flag or the updated one. The same kind is sent with a sequential next PC and with a jump target, which separates the delay-slot rewind from the plain case. Interrupts go in with each setting of the vector flag. Overflow goes in with each setting of the boot flag. Back-to-back entries with a changed exception shadow set show whether the swap is correctly skipped. A sweep over all kinds, with distinct side data, shows which kinds load which translation fields and which cause code each one gets. Idle cycles carrying junk data confirm that nothing moves without the strobe.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [3:0] {
    EK_INTR       = 4'd0,
    EK_TLB_MOD    = 4'd1,
    EK_TLBL_FILL  = 4'd2,
    EK_TLBL_INVAL = 4'd3,
    EK_TLBS_FILL  = 4'd4,
    EK_TLBS_INVAL = 4'd5,
    EK_ADR_LOAD   = 4'd6,
    EK_ADR_STORE  = 4'd7,
    EK_SYSCALL    = 4'd8,
    EK_BREAK      = 4'd9,
    EK_RESV_INSN  = 4'd10,
    EK_COP_UNUSE  = 4'd11,
    EK_OVERFLOW   = 4'd12,
    EK_TRAP       = 4'd13
  } exc_kind_e;

  localparam int CODE_W = 5;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              refill;
    logic              tlb;
    logic              adr_err;
    logic              cop;
    logic              intr;
    logic              ovf;
  } exc_class_t;

  localparam logic [31:0] RESET_VEC   = 32'hBFC0_0000;
  localparam logic [31:0] BOOT_OVF    = 32'hBFC0_0200;
  localparam logic [31:0] OFS_GENERAL = 32'h0000_0180;
  localparam logic [31:0] OFS_INTVEC  = 32'h0000_0200;
  localparam logic [31:0] INSN_BYTES  = 32'd4;

endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_entry_pkg::*;
(
  input  logic [3:0] kind,
  output exc_class_t cls
);

  exc_kind_e k;
  assign k = exc_kind_e'(kind);

  always_comb begin
    cls = '0;
    unique case (k)
      EK_INTR:       begin cls.code = 5'h00; cls.intr = 1'b1; end
      EK_TLB_MOD:    begin cls.code = 5'h01; cls.tlb = 1'b1; end
      EK_TLBL_FILL:  begin cls.code = 5'h02; cls.tlb = 1'b1; cls.refill = 1'b1; end
      EK_TLBL_INVAL: begin cls.code = 5'h02; cls.tlb = 1'b1; end
      EK_TLBS_FILL:  begin cls.code = 5'h03; cls.tlb = 1'b1; cls.refill = 1'b1; end
      EK_TLBS_INVAL: begin cls.code = 5'h03; cls.tlb = 1'b1; end
      EK_ADR_LOAD:   begin cls.code = 5'h04; cls.adr_err = 1'b1; end
      EK_ADR_STORE:  begin cls.code = 5'h05; cls.adr_err = 1'b1; end
      EK_SYSCALL:    cls.code = 5'h08;
      EK_BREAK:      cls.code = 5'h09;
      EK_RESV_INSN:  cls.code = 5'h0A;
      EK_COP_UNUSE:  begin cls.code = 5'h0B; cls.cop = 1'b1; end
      EK_OVERFLOW:   begin cls.code = 5'h0C; cls.ovf = 1'b1; end
      EK_TRAP:       cls.code = 5'h0D;
      default:       cls.code = 5'h0A;
    endcase
  end

  // R4: at most one class flag is active per kind
  always_comb begin
    p_class_onehot_r4: assert ($onehot0({cls.refill & ~cls.tlb, cls.adr_err, cls.cop, cls.intr, cls.ovf}))
      else $error("class flags overlap");
  end

endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  exc_class_t      cls,
  input  logic [XLEN-1:0] ebase,
  input  logic            old_exl,
  input  logic            bev,
  input  logic            iv,
  output logic [XLEN-1:0] handler
);

  localparam logic [XLEN-1:0] GEN  = XLEN'(OFS_GENERAL);
  localparam logic [XLEN-1:0] INTV = XLEN'(OFS_INTVEC);
  localparam logic [XLEN-1:0] BOVF = XLEN'(BOOT_OVF);

  always_comb begin
    if (cls.ovf && bev)          handler = BOVF;
    else if (cls.refill)         handler = old_exl ? ebase + GEN : ebase;
    else if (cls.intr && iv)     handler = ebase + INTV;
    else                         handler = ebase + GEN;
  end

  // R9: only the overflow/boot case may leave the ebase-relative window
  always_comb begin
    p_vec_window_r9: assert ((cls.ovf && bev) || (handler - ebase) <= INTV)
      else $error("handler outside vector window");
  end

endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ASID_W  = 8,
  parameter int VPN2_W  = 19,
  parameter int VPN2X_W = 2,
  parameter int SRS_W   = 4,
  parameter int COP_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid,
  input  exc_class_t         cls,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    npc,
  input  logic [XLEN-1:0]    badva,
  input  logic [ASID_W-1:0]  asid,
  input  logic [VPN2_W-1:0]  vpn2,
  input  logic [VPN2X_W-1:0] vpn2x,
  input  logic [VPN2_W-1:0]  ctx_vpn2,
  input  logic [COP_W-1:0]   cop,
  input  logic               bev,
  input  logic [SRS_W-1:0]   ess,
  input  logic [XLEN-1:0]    handler,
  output logic [XLEN-1:0]    pc_q,
  output logic [XLEN-1:0]    npc_q,
  output logic [XLEN-1:0]    nnpc_q,
  output logic               exl_q,
  output logic               cu1_q,
  output logic [CODE_W-1:0]  code_q,
  output logic               bd_q,
  output logic [COP_W-1:0]   ce_q,
  output logic [XLEN-1:0]    epc_q,
  output logic [XLEN-1:0]    badva_q,
  output logic [ASID_W-1:0]  asid_q,
  output logic [VPN2_W-1:0]  vpn2_q,
  output logic [VPN2X_W-1:0] vpn2x_q,
  output logic [VPN2_W-1:0]  ctxv_q,
  output logic [SRS_W-1:0]   css_q,
  output logic [SRS_W-1:0]   pss_q
);

  localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] RVEC  = XLEN'(RESET_VEC);

  logic [XLEN-1:0]    pc_d, npc_d, nnpc_d, epc_d, badva_d;
  logic               bd_d, swap;
  logic [CODE_W-1:0]  code_d;
  logic [COP_W-1:0]   ce_d;
  logic [ASID_W-1:0]  asid_d;
  logic [VPN2_W-1:0]  vpn2_d, ctxv_d;
  logic [VPN2X_W-1:0] vpn2x_d;
  logic [SRS_W-1:0]   css_d, pss_d;

  // next state, valid only when a request is taken
  always_comb begin
    pc_d    = handler;
    npc_d   = handler + STEP;
    nnpc_d  = handler + STEP + STEP;
    bd_d    = (pc + STEP) != npc;
    epc_d   = bd_d ? pc - STEP : pc;
    code_d  = cls.code;
    ce_d    = cls.cop ? cop : '0;
    swap    = !exl_q && !bev;
    css_d   = swap ? ess   : css_q;
    pss_d   = swap ? css_q : pss_q;
    badva_d = (cls.tlb || cls.adr_err) ? badva : badva_q;
    asid_d  = cls.tlb ? asid     : asid_q;
    vpn2_d  = cls.tlb ? vpn2     : vpn2_q;
    vpn2x_d = cls.tlb ? vpn2x    : vpn2x_q;
    ctxv_d  = cls.tlb ? ctx_vpn2 : ctxv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RVEC;
      npc_q   <= RVEC + STEP;
      nnpc_q  <= RVEC + STEP + STEP;
      exl_q   <= 1'b0;
      cu1_q   <= 1'b1;
      code_q  <= '0;
      bd_q    <= 1'b0;
      ce_q    <= '0;
      epc_q   <= '0;
      badva_q <= '0;
      asid_q  <= '0;
      vpn2_q  <= '0;
      vpn2x_q <= '0;
      ctxv_q  <= '0;
      css_q   <= '0;
      pss_q   <= '0;
    end else if (valid) begin
      pc_q    <= pc_d;
      npc_q   <= npc_d;
      nnpc_q  <= nnpc_d;
      exl_q   <= 1'b1;
      code_q  <= code_d;
      bd_q    <= bd_d;
      ce_q    <= ce_d;
      epc_q   <= epc_d;
      badva_q <= badva_d;
      asid_q  <= asid_d;
      vpn2_q  <= vpn2_d;
      vpn2x_q <= vpn2x_d;
      ctxv_q  <= ctxv_d;
      css_q   <= css_d;
      pss_q   <= pss_d;
    end
  end

  p_exl_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> exl_q);

  p_delay_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (bd_q == (($past(pc) + STEP) != $past(npc))) &&
              (epc_q == (bd_q ? $past(pc) - STEP : $past(pc))));

  p_ce_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !cls.cop |=> ce_q == '0);

  p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !exl_q && !bev |=> (css_q == $past(ess)) && (pss_q == $past(css_q)));

  p_pc_seq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (npc_q == pc_q + STEP) && (nnpc_q == npc_q + STEP));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(pc_q) && $stable(epc_q) && $stable(code_q) &&
               $stable(exl_q) && $stable(badva_q) && $stable(css_q));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ASID_W  = 8,
  parameter int VPN2_W  = 19,
  parameter int VPN2X_W = 2,
  parameter int SRS_W   = 4,
  parameter int COP_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_valid,
  input  logic [3:0]         exc_kind,
  input  logic [XLEN-1:0]    exc_pc,
  input  logic [XLEN-1:0]    exc_npc,
  input  logic [XLEN-1:0]    exc_badva,
  input  logic [ASID_W-1:0]  exc_asid,
  input  logic [VPN2_W-1:0]  exc_vpn2,
  input  logic [VPN2X_W-1:0] exc_vpn2x,
  input  logic [VPN2_W-1:0]  exc_ctx_vpn2,
  input  logic [COP_W-1:0]   exc_cop,
  input  logic [XLEN-1:0]    cfg_ebase,
  input  logic               cfg_bev,
  input  logic               cfg_iv,
  input  logic [SRS_W-1:0]   cfg_ess,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    npc_o,
  output logic [XLEN-1:0]    nnpc_o,
  output logic               exl_o,
  output logic               cu1_o,
  output logic [CODE_W-1:0]  exc_code_o,
  output logic               bd_o,
  output logic [COP_W-1:0]   ce_o,
  output logic [XLEN-1:0]    epc_o,
  output logic [XLEN-1:0]    badva_o,
  output logic [ASID_W-1:0]  hi_asid_o,
  output logic [VPN2_W-1:0]  hi_vpn2_o,
  output logic [VPN2X_W-1:0] hi_vpn2x_o,
  output logic [VPN2_W-1:0]  ctx_vpn2_o,
  output logic [SRS_W-1:0]   css_o,
  output logic [SRS_W-1:0]   pss_o
);

  exc_class_t      cls;
  logic [XLEN-1:0] handler;

  exc_decode u_decode (
    .kind (exc_kind),
    .cls  (cls)
  );

  exc_vector #(.XLEN(XLEN)) u_vector (
    .cls     (cls),
    .ebase   (cfg_ebase),
    .old_exl (exl_o),
    .bev     (cfg_bev),
    .iv      (cfg_iv),
    .handler (handler)
  );

  exc_state #(
    .XLEN(XLEN), .ASID_W(ASID_W), .VPN2_W(VPN2_W),
    .VPN2X_W(VPN2X_W), .SRS_W(SRS_W), .COP_W(COP_W)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (exc_valid),
    .cls      (cls),
    .pc       (exc_pc),
    .npc      (exc_npc),
    .badva    (exc_badva),
    .asid     (exc_asid),
    .vpn2     (exc_vpn2),
    .vpn2x    (exc_vpn2x),
    .ctx_vpn2 (exc_ctx_vpn2),
    .cop      (exc_cop),
    .bev      (cfg_bev),
    .ess      (cfg_ess),
    .handler  (handler),
    .pc_q     (pc_o),
    .npc_q    (npc_o),
    .nnpc_q   (nnpc_o),
    .exl_q    (exl_o),
    .cu1_q    (cu1_o),
    .code_q   (exc_code_o),
    .bd_q     (bd_o),
    .ce_q     (ce_o),
    .epc_q    (epc_o),
    .badva_q  (badva_o),
    .asid_q   (hi_asid_o),
    .vpn2_q   (hi_vpn2_o),
    .vpn2x_q  (hi_vpn2x_o),
    .ctxv_q   (ctx_vpn2_o),
    .css_q    (css_o),
    .pss_q    (pss_o)
  );

endmodule

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_valid;
  logic [3:0]  exc_kind;
  logic [31:0] exc_pc, exc_npc, exc_badva, cfg_ebase;
  logic [7:0]  exc_asid;
  logic [18:0] exc_vpn2, exc_ctx_vpn2;
  logic [1:0]  exc_vpn2x, exc_cop;
  logic        cfg_bev, cfg_iv;
  logic [3:0]  cfg_ess;
  logic [31:0] pc_o, npc_o, nnpc_o, epc_o, badva_o;
  logic        exl_o, cu1_o, bd_o;
  logic [4:0]  exc_code_o;
  logic [1:0]  ce_o, hi_vpn2x_o;
  logic [7:0]  hi_asid_o;
  logic [18:0] hi_vpn2_o, ctx_vpn2_o;
  logic [3:0]  css_o, pss_o;

  always #4 clk = ~clk;

  exc_entry_ctrl dut (.*);

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [31:0] m_pc, m_epc, m_badva;
  logic        m_exl, m_bd, m_cu1;
  logic [4:0]  m_code;
  logic [1:0]  m_ce, m_vpn2x;
  logic [7:0]  m_asid;
  logic [18:0] m_vpn2, m_cvpn;
  logic [3:0]  m_css, m_pss;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string hreq);
    chk(hreq,  "pc",    pc_o, m_pc);
    chk("R11", "npc",   npc_o, m_pc + 4);
    chk("R11", "nnpc",  nnpc_o, m_pc + 8);
    chk("R2",  "exl",   32'(exl_o), 32'(m_exl));
    chk("R1",  "cu1",   32'(cu1_o), 32'(m_cu1));
    chk("R4",  "code",  32'(exc_code_o), 32'(m_code));
    chk("R3",  "bd",    32'(bd_o), 32'(m_bd));
    chk("R3",  "epc",   epc_o, m_epc);
    chk("R5",  "ce",    32'(ce_o), 32'(m_ce));
    chk("R10", "badva", badva_o, m_badva);
    chk("R10", "asid",  32'(hi_asid_o), 32'(m_asid));
    chk("R10", "vpn2",  32'(hi_vpn2_o), 32'(m_vpn2));
    chk("R10", "vpn2x", 32'(hi_vpn2x_o), 32'(m_vpn2x));
    chk("R10", "cvpn",  32'(ctx_vpn2_o), 32'(m_cvpn));
    chk("R6",  "css",   32'(css_o), 32'(m_css));
    chk("R6",  "pss",   32'(pss_o), 32'(m_pss));
  endtask

  function automatic logic [4:0] ref_code(input int k);
    case (k)
      0: return 5'h0;   1: return 5'h1;   2: return 5'h2;   3: return 5'h2;
      4: return 5'h3;   5: return 5'h3;   6: return 5'h4;   7: return 5'h5;
      8: return 5'h8;   9: return 5'h9;   11: return 5'hB;  12: return 5'hC;
      13: return 5'hD;  default: return 5'hA;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    exc_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_pc = 32'hBFC00000; m_exl = 0; m_cu1 = 1; m_code = 0; m_bd = 0; m_ce = 0;
    m_epc = 0; m_badva = 0; m_asid = 0; m_vpn2 = 0; m_vpn2x = 0; m_cvpn = 0;
    m_css = 0; m_pss = 0;
    @(negedge clk);
    check_all("R1");
  endtask

  task automatic do_exc(input int k, input logic [31:0] pc, input logic [31:0] npc,
                        input logic [31:0] bva, input logic [7:0] asid, input logic [18:0] vpn2,
                        input logic [1:0] vx, input logic [18:0] cv, input logic [1:0] cop,
                        input string hreq);
    logic [31:0] h;
    bit tlb, refill, adr;
    @(negedge clk);
    exc_valid = 1'b1; exc_kind = 4'(k); exc_pc = pc; exc_npc = npc; exc_badva = bva;
    exc_asid = asid; exc_vpn2 = vpn2; exc_vpn2x = vx; exc_ctx_vpn2 = cv; exc_cop = cop;
    tlb = (k >= 1 && k <= 5);
    refill = (k == 2 || k == 4);
    adr = (k == 6 || k == 7);
    if (k == 12 && cfg_bev) h = 32'hBFC00200;
    else if (refill) h = m_exl ? cfg_ebase + 32'h180 : cfg_ebase;
    else if (k == 0 && cfg_iv) h = cfg_ebase + 32'h200;
    else h = cfg_ebase + 32'h180;
    if (!m_exl && !cfg_bev) begin m_pss = m_css; m_css = cfg_ess; end
    m_exl = 1'b1;
    m_pc = h;
    m_bd = (pc + 4 != npc);
    m_epc = m_bd ? pc - 4 : pc;
    m_code = ref_code(k);
    m_ce = (k == 11) ? cop : 2'd0;
    if (tlb || adr) m_badva = bva;
    if (tlb) begin m_asid = asid; m_vpn2 = vpn2; m_vpn2x = vx; m_cvpn = cv; end
    @(negedge clk);
    exc_valid = 1'b0;
    check_all(hreq);
  endtask

  task automatic idle_junk();
    @(negedge clk);
    exc_valid = 1'b0; exc_kind = 4'd2; exc_pc = 32'hDEAD0000; exc_npc = 32'h1;
    exc_badva = 32'hFFFF_FFFF; exc_asid = 8'hFF; exc_vpn2 = '1; exc_vpn2x = 2'b11;
    exc_ctx_vpn2 = '1; exc_cop = 2'd3; cfg_ess = 4'hF;
    @(negedge clk);
    check_all("R12");
    @(negedge clk);
    check_all("R12");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; exc_valid = 0; exc_kind = 0; exc_pc = 0; exc_npc = 0; exc_badva = 0;
    exc_asid = 0; exc_vpn2 = 0; exc_vpn2x = 0; exc_ctx_vpn2 = 0; exc_cop = 0;
    cfg_ebase = 32'h8000_0000; cfg_bev = 0; cfg_iv = 0; cfg_ess = 4'd5;

    do_reset();                                          // R1
    idle_junk();                                         // R12 before any entry
    cfg_ess = 4'd5;
    // R6 swap on first entry, R9 general vector, R3 sequential PC
    do_exc(8, 32'h1000, 32'h1004, 32'h11, 8'h1, 19'h1, 2'd1, 19'h1, 2'd0, "R9");
    // R2 EXL already set, R3 delay slot, R6 no swap with new ess
    cfg_ess = 4'd7;
    do_exc(9, 32'h2000, 32'h3000, 32'h22, 8'h2, 19'h2, 2'd2, 19'h2, 2'd0, "R9");
    // R7 refill with old EXL set -> +0x180, R10 fields loaded
    do_exc(2, 32'h4000, 32'h4004, 32'hA000_1234, 8'h5A, 19'h1_2345, 2'd3, 19'h5_4321, 2'd0, "R7");
    idle_junk();                                         // R12 after entries

    do_reset();
    cfg_ess = 4'd3; cfg_ebase = 32'h9000_1000;
    // R7 refill with old EXL clear -> ebase
    do_exc(4, 32'h5000, 32'h4000, 32'hB000_0040, 8'h33, 19'h0_0ABC, 2'd1, 19'h7_7777, 2'd0, "R7");
    // R8 interrupt vectors
    cfg_iv = 1;
    do_exc(0, 32'h6000, 32'h6004, 32'h0, 8'h0, 19'h0, 2'd0, 19'h0, 2'd0, "R8");
    cfg_iv = 0;
    do_exc(0, 32'h6100, 32'h6104, 32'h0, 8'h0, 19'h0, 2'd0, 19'h0, 2'd0, "R8");
    // R5 coprocessor number loaded, then cleared by trap
    do_exc(11, 32'h7000, 32'h7004, 32'h0, 8'h0, 19'h0, 2'd0, 19'h0, 2'd3, "R9");
    do_exc(13, 32'h7100, 32'h7104, 32'h0, 8'h0, 19'h0, 2'd0, 19'h0, 2'd2, "R9");
    // R10 address error loads only BadVAddr
    do_exc(7, 32'h7200, 32'h7204, 32'hC0DE_0003, 8'hEE, 19'h6_6666, 2'd2, 19'h3_3333, 2'd0, "R9");

    do_reset();
    // R9 overflow with boot flag; R6 no swap when bev set
    cfg_bev = 1; cfg_ess = 4'd9;
    do_exc(12, 32'h8000, 32'h8004, 32'h0, 8'h0, 19'h0, 2'd0, 19'h0, 2'd0, "R9");
    cfg_bev = 0;
    do_exc(12, 32'h8100, 32'h8200, 32'h0, 8'h0, 19'h0, 2'd0, 19'h0, 2'd0, "R9");

    // R4 sweep over all kinds, R10 per-kind field loading
    for (int k = 0; k < 16; k++) begin
      do_exc(k, 32'h100 * (k + 1), 32'h100 * (k + 1) + 4, 32'h4000_0000 + k,
             8'(k + 16), 19'(k * 3 + 1), 2'(k), 19'(k * 5 + 2), 2'(k), "R4");
    end
    idle_junk();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule